// File: doc/BRIEF.md
# Sequential Integer Divider (Byte and Word Sizes)

This block is the division engine of a 16-bit-class CPU datapath. It takes a double-width dividend and a single-width divisor and returns the remainder and the quotient together, packed into one destination-register image. One engine handles two sizes. Byte size divides a 16-bit dividend by an 8-bit divisor into an 8-bit quotient and an 8-bit remainder. Word size divides a 32-bit dividend by a 16-bit divisor into a 16-bit quotient and a 16-bit remainder. A mode input selects unsigned or two's-complement signed operands.

The dividend, divisor and mode are sampled on a clock edge where `start_i` is high and the unit is idle. The unit converts signed operands to magnitudes. It then runs a restoring shift-subtract loop that yields one quotient bit per clock: 8 clocks for byte size, 16 for word size. One further cycle applies the signs and packs the result. A zero divisor skips the loop and ends after one cycle, returning the dividend unchanged. `done_o` pulses for one cycle when the result and the two flags are updated. If the true quotient does not fit in the quotient field, the result value is not specified.

Top module: `sdiv_unit`

## Requirements
- R1: In byte size, only `dividend_i[15:0]` and `divisor_i[7:0]` take part in the division. The result is `{dividend_i[31:16], remainder[7:0], quotient[7:0]}`: the remainder in bits 15:8 and the quotient in bits 7:0, with bits 31:16 passed through unchanged.
- R2: In word size, the result is `{remainder[15:0], quotient[15:0]}`: the remainder in bits 31:16 and the quotient in bits 15:0.
- R3: With `signed_i` high, both operands are two's complement at the selected size. The quotient rounds toward zero, is negative when the operand signs differ, and the remainder carries the sign of the dividend. Each field is two's complement at its own width.
- R4: A division with a nonzero divisor raises `done_o` in the cycle that follows the 9th clock edge (byte size) or the 17th clock edge (word size) after the edge that accepted `start_i`.
- R5: When the divisor is zero at the selected size (`divisor_i[7:0]` in byte size, `divisor_i[15:0]` in word size), `done_o` rises after the first edge following acceptance. All 32 bits of `result_o` equal the accepted dividend, and `zero_o` is 1.
- R6: At each done, `zero_o` reports a zero divisor at the selected size. `neg_o` equals the divisor's sign bit (bit 7 in byte size, bit 15 in word size) in signed mode and is 0 in unsigned mode.
- R7: `done_o` is high for exactly one cycle per operation. `result_o`, `zero_o` and `neg_o` change only in that cycle and hold their values otherwise.
- R8: `busy_o` is high from the cycle after acceptance until the done cycle, where it is low. While `busy_o` is high, `start_i` is ignored, starts no operation and alters no operand.
- R9: After reset, `result_o` is 0 and `done_o`, `busy_o`, `zero_o` and `neg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; taken only when idle |
| word_i | input | 1 | 1 = word size (32/16), 0 = byte size (16/8) |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend register image |
| divisor_i | input | 16 | Divisor register image |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when result and flags update |
| result_o | output | 32 | Packed remainder and quotient |
| zero_o | output | 1 | Divisor was zero |
| neg_o | output | 1 | Divisor was negative (signed mode only) |

## Verification
Counting from the edge that accepts `start_i`, a result is due after 9 edges in byte size, 17 in word size, and 1 for a zero divisor. The bench drives `start_i` and operands on falling edges. After the accepting edge, it counts falling edges until `done_o` is seen. It compares that count with the expected latency and samples the result and flags at that same falling edge. At the following falling edge, it confirms that `done_o` has dropped and that the result has held. Starts issued while busy are checked by confirming that the first operation's result and latency are unaffected and that no extra done pulse follows.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2,
      ST_ZDIV = 2'd3
   } div_state_t;

   typedef struct packed {
      logic word;
      logic sgn;
      logic quo_neg;
      logic rem_neg;
      logic dvs_zero;
      logic dvs_neg;
   } div_ctl_t;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
   parameter int HALF_W = 16
) (
   input  logic                  word_i,
   input  logic                  signed_i,
   input  logic [2*HALF_W-1:0]   dividend_i,
   input  logic [HALF_W-1:0]     divisor_i,
   output logic [HALF_W-1:0]     rem_init_o,
   output logic [HALF_W-1:0]     quo_init_o,
   output logic [HALF_W-1:0]     dvs_mag_o,
   output logic                  quo_neg_o,
   output logic                  rem_neg_o,
   output logic                  dvs_zero_o,
   output logic                  dvs_sign_o
);
   localparam int BYTE_W = HALF_W / 2;
   localparam int DVD_W  = 2 * HALF_W;

   if (HALF_W < 4 || (HALF_W % 2) != 0) begin : g_bad_width
      $error("sdiv_prep: HALF_W must be even and at least 4");
   end

   // byte-size lane: HALF_W-bit dividend, BYTE_W-bit divisor
   logic [HALF_W-1:0] b_dvd, b_dmag;
   logic [BYTE_W-1:0] b_dvs, b_vmag;
   logic              b_dsgn, b_vsgn;

   // word-size lane: DVD_W-bit dividend, HALF_W-bit divisor
   logic [DVD_W-1:0]  w_dvd, w_dmag;
   logic [HALF_W-1:0] w_dvs, w_vmag;
   logic              w_dsgn, w_vsgn;

   always_comb begin
      b_dvd  = dividend_i[HALF_W-1:0];
      b_dvs  = divisor_i[BYTE_W-1:0];
      b_dsgn = signed_i & b_dvd[HALF_W-1];
      b_vsgn = signed_i & b_dvs[BYTE_W-1];
      b_dmag = b_dsgn ? (~b_dvd + 1'b1) : b_dvd;
      b_vmag = b_vsgn ? (~b_dvs + 1'b1) : b_dvs;

      w_dvd  = dividend_i;
      w_dvs  = divisor_i;
      w_dsgn = signed_i & w_dvd[DVD_W-1];
      w_vsgn = signed_i & w_dvs[HALF_W-1];
      w_dmag = w_dsgn ? (~w_dvd + 1'b1) : w_dvd;
      w_vmag = w_vsgn ? (~w_dvs + 1'b1) : w_dvs;
   end

   always_comb begin
      if (word_i) begin
         rem_init_o = w_dmag[DVD_W-1:HALF_W];
         quo_init_o = w_dmag[HALF_W-1:0];
         dvs_mag_o  = w_vmag;
         quo_neg_o  = w_dsgn ^ w_vsgn;
         rem_neg_o  = w_dsgn;
         dvs_zero_o = (w_dvs == '0);
         dvs_sign_o = w_dvs[HALF_W-1];
      end else begin
         // the low dividend byte is left-aligned so its MSB leads the shift
         rem_init_o = {{BYTE_W{1'b0}}, b_dmag[HALF_W-1:BYTE_W]};
         quo_init_o = {b_dmag[BYTE_W-1:0], {BYTE_W{1'b0}}};
         dvs_mag_o  = {{BYTE_W{1'b0}}, b_vmag};
         quo_neg_o  = b_dsgn ^ b_vsgn;
         rem_neg_o  = b_dsgn;
         dvs_zero_o = (b_dvs == '0);
         dvs_sign_o = b_dvs[BYTE_W-1];
      end
   end

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
   parameter int HALF_W = 16
) (
   input  logic [HALF_W-1:0] rem_i,
   input  logic [HALF_W-1:0] quo_i,
   input  logic [HALF_W-1:0] dvs_i,
   output logic [HALF_W-1:0] rem_o,
   output logic [HALF_W-1:0] quo_o
);
   localparam int SH_W = HALF_W + 1;

   logic [SH_W-1:0] shifted;
   logic [SH_W:0]   trial;
   logic            fits;

   always_comb begin
      shifted = {rem_i, quo_i[HALF_W-1]};
      trial   = {1'b0, shifted} - {2'b00, dvs_i};
      fits    = ~trial[SH_W];
      rem_o   = fits ? trial[HALF_W-1:0] : shifted[HALF_W-1:0];
      quo_o   = {quo_i[HALF_W-2:0], fits};
   end

endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
   parameter int HALF_W = 16
) (
   input  logic                word_i,
   input  logic                quo_neg_i,
   input  logic                rem_neg_i,
   input  logic [HALF_W-1:0]   rem_i,
   input  logic [HALF_W-1:0]   quo_i,
   input  logic [HALF_W-1:0]   upper_i,
   output logic [2*HALF_W-1:0] result_o
);
   localparam int BYTE_W = HALF_W / 2;

   logic [BYTE_W-1:0] b_q, b_r;
   logic [HALF_W-1:0] w_q, w_r;

   always_comb begin
      b_q = quo_neg_i ? (~quo_i[BYTE_W-1:0] + 1'b1) : quo_i[BYTE_W-1:0];
      b_r = rem_neg_i ? (~rem_i[BYTE_W-1:0] + 1'b1) : rem_i[BYTE_W-1:0];
      w_q = quo_neg_i ? (~quo_i + 1'b1) : quo_i;
      w_r = rem_neg_i ? (~rem_i + 1'b1) : rem_i;
      result_o = word_i ? {w_r, w_q} : {upper_i, b_r, b_q};
   end

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
   parameter int HALF_W = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic                word_i,
   input  logic                signed_i,
   input  logic [2*HALF_W-1:0] dividend_i,
   input  logic [HALF_W-1:0]   divisor_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [2*HALF_W-1:0] result_o,
   output logic                zero_o,
   output logic                neg_o
);
   import sdiv_pkg::*;

   localparam int BYTE_W = HALF_W / 2;
   localparam int DVD_W  = 2 * HALF_W;
   localparam int CNT_W  = $clog2(HALF_W + 1);
   localparam int LAT_W  = $clog2(HALF_W + 3);

   if (HALF_W < 4 || (HALF_W % 2) != 0) begin : g_bad_width
      $error("sdiv_unit: HALF_W must be even and at least 4");
   end

   div_state_t        st_q;
   div_ctl_t          ctl_q;
   logic [DVD_W-1:0]  dvd_q;
   logic [HALF_W-1:0] rem_q, quo_q, dvs_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [LAT_W-1:0]  lat_q;

   logic [HALF_W-1:0] rem_init, quo_init, dvs_mag, step_rem, step_quo;
   logic              pre_qneg, pre_rneg, pre_zero, pre_sign;
   logic [DVD_W-1:0]  fix_res;
   logic              accept;

   assign accept = (st_q == ST_IDLE) && start_i;
   assign busy_o = (st_q != ST_IDLE);

   sdiv_prep #(.HALF_W(HALF_W)) u_prep (
      .word_i     (word_i),
      .signed_i   (signed_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .rem_init_o (rem_init),
      .quo_init_o (quo_init),
      .dvs_mag_o  (dvs_mag),
      .quo_neg_o  (pre_qneg),
      .rem_neg_o  (pre_rneg),
      .dvs_zero_o (pre_zero),
      .dvs_sign_o (pre_sign)
   );

   sdiv_step #(.HALF_W(HALF_W)) u_step (
      .rem_i (rem_q),
      .quo_i (quo_q),
      .dvs_i (dvs_q),
      .rem_o (step_rem),
      .quo_o (step_quo)
   );

   sdiv_fixup #(.HALF_W(HALF_W)) u_fix (
      .word_i    (ctl_q.word),
      .quo_neg_i (ctl_q.quo_neg),
      .rem_neg_i (ctl_q.rem_neg),
      .rem_i     (rem_q),
      .quo_i     (quo_q),
      .upper_i   (dvd_q[DVD_W-1:HALF_W]),
      .result_o  (fix_res)
   );

   // sequencer: accept, iterate, fix signs, report
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         ctl_q    <= '0;
         dvd_q    <= '0;
         rem_q    <= '0;
         quo_q    <= '0;
         dvs_q    <= '0;
         cnt_q    <= '0;
         done_o   <= 1'b0;
         result_o <= '0;
         zero_o   <= 1'b0;
         neg_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  dvd_q          <= dividend_i;
                  rem_q          <= rem_init;
                  quo_q          <= quo_init;
                  dvs_q          <= dvs_mag;
                  ctl_q.word     <= word_i;
                  ctl_q.sgn      <= signed_i;
                  ctl_q.quo_neg  <= pre_qneg;
                  ctl_q.rem_neg  <= pre_rneg;
                  ctl_q.dvs_zero <= pre_zero;
                  ctl_q.dvs_neg  <= signed_i & pre_sign;
                  cnt_q          <= word_i ? CNT_W'(HALF_W) : CNT_W'(BYTE_W);
                  st_q           <= pre_zero ? ST_ZDIV : ST_RUN;
               end
            end
            ST_RUN: begin
               rem_q <= step_rem;
               quo_q <= step_quo;
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) st_q <= ST_FIX;
            end
            ST_FIX: begin
               result_o <= fix_res;
               zero_o   <= ctl_q.dvs_zero;
               neg_o    <= ctl_q.dvs_neg;
               done_o   <= 1'b1;
               st_q     <= ST_IDLE;
            end
            ST_ZDIV: begin
               result_o <= dvd_q;
               zero_o   <= ctl_q.dvs_zero;
               neg_o    <= ctl_q.dvs_neg;
               done_o   <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // edges elapsed since the accepting edge, for the latency checks
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lat_q <= '0;
      else if (accept)  lat_q <= '0;
      else if (busy_o)  lat_q <= lat_q + 1'b1;
   end

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);                                                     // R7
   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> ($stable(result_o) && $stable(zero_o) && $stable(neg_o)));   // R7
   AST_BUSY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> ($stable(dvd_q) && $stable(dvs_q) && $stable(ctl_q)));        // R8
   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);                                                     // R8
   AST_RUN_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN) |-> (cnt_q != '0));                                     // R4
   AST_DIV_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !zero_o) |-> (lat_q == (ctl_q.word ? LAT_W'(HALF_W + 1) : LAT_W'(BYTE_W + 1)))); // R4
   AST_ZERO_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && zero_o) |-> ((lat_q == LAT_W'(1)) && (result_o == dvd_q)));   // R5
   AST_NEG_UNSIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !ctl_q.sgn) |-> !neg_o);                                      // R6

endmodule

// File: tb/sdiv_unit_test.sv
module sdiv_unit_test;
   localparam int HALF_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        word = 1'b0;
   logic        sgn = 1'b0;
   logic [31:0] dvd = '0;
   logic [15:0] dvs = '0;
   logic        busy, done, zero, neg;
   logic [31:0] result;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   sdiv_unit #(.HALF_W(HALF_W)) uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word),
      .signed_i(sgn), .dividend_i(dvd), .divisor_i(dvs),
      .busy_o(busy), .done_o(done), .result_o(result),
      .zero_o(zero), .neg_o(neg)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic wd, input logic sg,
                                         input logic [31:0] dd, input logic [15:0] ds);
      longint a, b, q, r;
      if (!wd) begin
         a = sg ? longint'($signed(dd[15:0])) : longint'(dd[15:0]);
         b = sg ? longint'($signed(ds[7:0]))  : longint'(ds[7:0]);
         if (b == 0) return dd;
         q = a / b; r = a % b;
         return {dd[31:16], r[7:0], q[7:0]};
      end else begin
         a = sg ? longint'($signed(dd)) : longint'(dd);
         b = sg ? longint'($signed(ds)) : longint'(ds);
         if (b == 0) return dd;
         q = a / b; r = a % b;
         return {r[15:0], q[15:0]};
      end
   endfunction

   // Runs one division and checks result, latency, flags and the done pulse.
   task automatic run_op(input string req, input logic wd, input logic sg,
                         input logic [31:0] dd, input logic [15:0] ds);
      int n;
      logic z;
      logic [31:0] held;
      z = wd ? (ds == 16'h0) : (ds[7:0] == 8'h0);
      @(negedge clk);
      start = 1'b1; word = wd; sgn = sg; dvd = dd; dvs = ds;
      @(negedge clk);
      start = 1'b0;
      check("R8", "busy after accept", 32'(busy), 32'd1);
      n = 0;
      while (!done && n < 64) begin
         @(negedge clk);
         n++;
      end
      check("R4/R5", "latency", 32'(n), z ? 32'd1 : (wd ? 32'd17 : 32'd9));
      check(req, "result", result, model(wd, sg, dd, ds));
      check("R6", "zero flag", 32'(zero), 32'(z));
      check("R6", "neg flag", 32'(neg), 32'(sg & (wd ? ds[15] : ds[7])));
      check("R8", "busy low at done", 32'(busy), 32'd0);
      held = result;
      @(negedge clk);
      check("R7", "done single pulse", 32'(done), 32'd0);
      check("R7", "result held", result, held);
   endtask

   task automatic test_reset();
      check("R9", "reset result", result, 32'h0);
      check("R9", "reset done", 32'(done), 32'd0);
      check("R9", "reset busy", 32'(busy), 32'd0);
      check("R9", "reset flags", {30'd0, zero, neg}, 32'd0);
   endtask

   task automatic test_byte_unsigned();
      run_op("R1", 1'b0, 1'b0, 32'hABCD_1234, 16'h0056);
      run_op("R1", 1'b0, 1'b0, 32'h5A5A_7F00, 16'hFF80);   // upper divisor byte ignored
      run_op("R1", 1'b0, 1'b0, 32'h0000_00FE, 16'h00FF);
   endtask

   task automatic test_word_unsigned();
      run_op("R2", 1'b1, 1'b0, 32'h1234_5678, 16'hFEDC);
      run_op("R2", 1'b1, 1'b0, 32'h0000_FFFF, 16'h0001);
      run_op("R2", 1'b1, 1'b0, 32'h0001_0000, 16'h8000);   // neg stays 0 in unsigned
   endtask

   task automatic test_signed();
      run_op("R3", 1'b0, 1'b1, 32'h0000_FF9C, 16'h0007);   // -100 / 7
      run_op("R3", 1'b0, 1'b1, 32'h0000_0064, 16'h00F9);   // 100 / -7
      run_op("R3", 1'b0, 1'b1, 32'h7777_FF9C, 16'h00F9);   // -100 / -7
      run_op("R3", 1'b0, 1'b1, 32'h0000_FC18, 16'h009C);   // -1000 / -100
      run_op("R3", 1'b1, 1'b1, 32'hFFF0_BDC0, 16'd300);    // -1000000 / 300
      run_op("R3", 1'b1, 1'b1, 32'h075B_CD15, 16'h8AD0);   // 123456789 / -30000
   endtask

   task automatic test_zero_divisor();
      run_op("R5", 1'b0, 1'b0, 32'hCAFE_BEEF, 16'hAB00);   // byte size sees zero
      run_op("R5", 1'b1, 1'b1, 32'h8765_4321, 16'h0000);
   endtask

   task automatic test_start_while_busy();
      int n;
      int extra;
      @(negedge clk);
      start = 1'b1; word = 1'b1; sgn = 1'b0; dvd = 32'h0042_1111; dvs = 16'h0123;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      repeat (3) begin @(negedge clk); n++; end
      start = 1'b1; word = 1'b0; sgn = 1'b1; dvd = 32'h0000_FFFF; dvs = 16'h0000;
      @(negedge clk); n++;
      start = 1'b0; dvd = '0; dvs = 16'h0001;
      while (!done && n < 64) begin
         @(negedge clk);
         n++;
      end
      check("R8", "latency unchanged by ignored start", 32'(n), 32'd17);
      check("R8", "result of first operation", result,
            model(1'b1, 1'b0, 32'h0042_1111, 16'h0123));
      check("R8", "zero flag of first operation", 32'(zero), 32'd0);
      extra = 0;
      repeat (25) begin
         @(negedge clk);
         if (done || busy) extra++;
      end
      check("R8", "no second operation started", 32'(extra), 32'd0);
   endtask

   initial begin
      #20000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_byte_unsigned();
      test_word_unsigned();
      test_signed();
      test_zero_divisor();
      test_start_while_busy();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule